// File: doc/BRIEF.md
# ADC Control and Sequencing Front End

This block is the digital side of an 8-bit analog-to-digital converter as a CPU sees it on its register bus. Software selects an input channel and a converter clock rate, then turns the converter on. The block divides the CPU clock down to the converter clock and counts out a fixed-length conversion. At the end it captures the sample presented by the analog macro and raises a completion flag that software polls.

Three byte-wide registers sit at word addresses 0 (control/status), 1 (result, read-only) and 2 (clock/amplifier control). Read data is combinational on the address. A read strobe only matters for its side effect on the flag. The flag is cleared in two ways: by reading the result, or by writing the control/status register. A control/status write that sets the enable bit abandons any conversion in flight and starts a fresh one on the channel just written. Each start produces exactly one conversion. The block then idles until software writes control/status again.

Top module: `adc_seq_frontend`

## Requirements
- R1: After reset, all three registers read 00h, `conv_busy` is 0 and `chan_sel` is 0.
- R2: Control/status reads back as {flag at bit 7, speed at bit 6, enable at bit 5, 0, 0, channel at bits 2:0}. Writes to bits 7 and 4:3 have no effect.
- R3: Clock/amplifier control keeps only slow (bit 3) and amplifier select (bit 2). All other bits read 0, and `amp_sel` follows bit 2.
- R4: A control/status write with enable=1 sets `conv_busy`. Exactly CONV_CYCLES×D clock cycles after that write edge, the result register holds `sample_in` and the flag reads 1. D is 2 when slow=0 and speed=0, and 1 when slow=0 and speed=1.
- R5: With slow=1, D is 4 whatever the speed bit.
- R6: Reading the result register clears the flag on that read's edge. Reads of the other two registers leave the flag set.
- R7: Any control/status write clears the flag, including a write with enable=0.
- R8: A control/status write with enable=1 during a conversion restarts it. The result is due CONV_CYCLES×D cycles after the new write, and `chan_sel` shows the new channel.
- R9: A control/status write with enable=0 drops `conv_busy` on that edge. The flag stays clear and the result register keeps its old value afterwards.
- R10: `chan_sel` presents the stored 3-bit channel, codes 5 to 7 included.
- R11: `conv_tick` pulses once every D cycles while a conversion runs, CONV_CYCLES times per conversion, and never while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 result, 2 clock/amplifier |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| sample_in | input | 8 | Value from the analog converter |
| chan_sel | output | 3 | Channel to the analog multiplexer |
| amp_sel | output | 1 | Amplifier select to the analog side |
| conv_busy | output | 1 | Conversion in progress |
| conv_tick | output | 1 | Converter clock enable |

## Verification
A result is due exactly CONV_CYCLES×D cycles after the write edge that started it. The bench therefore looks at the flag half a cycle before that edge, where it must still be 0, and half a cycle after it, where it must be 1 with the result captured. Clears caused by a read or a write take effect on the strobe's own edge, so the bench checks them at the following falling edge. Register contents and the flag are read back through the combinational data path with no read strobe, so the observation itself never clears the flag.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam int BUS_AW = 2;
  localparam int DW     = 8;
  localparam int CHW    = 3;

  localparam logic [BUS_AW-1:0] A_CSR  = 2'd0;
  localparam logic [BUS_AW-1:0] A_DATA = 2'd1;
  localparam logic [BUS_AW-1:0] A_AMP  = 2'd2;

  // enum value is the divider terminal count (divide ratio minus one)
  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY4 = 2'd3
  } div_sel_e;

  function automatic div_sel_e pick_div(input logic slow, input logic speed);
    if (slow)       return DIV_BY4;
    else if (speed) return DIV_BY1;
    else            return DIV_BY2;
  endfunction
endpackage

// File: rtl/adc_fe_clkdiv.sv
module adc_fe_clkdiv
  import adc_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     restart,
  input  div_sel_e div_sel,
  output logic     tick
);
  logic [1:0] cnt_q, cnt_d;
  logic       at_lim;

  assign at_lim = (cnt_q >= 2'(div_sel));
  assign tick   = run && !restart && at_lim;

  always_comb begin
    if (!run || restart) cnt_d = '0;
    else if (at_lim)     cnt_d = '0;
    else                 cnt_d = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_fe_seq.sv
module adc_fe_seq #(
  parameter int CONV_CYCLES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kill,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cyc_q, cyc_d;

  assign busy = busy_q;
  assign done = busy_q && tick && (cyc_q == LAST) && !start && !kill;

  always_comb begin
    busy_d = busy_q;
    cyc_d  = cyc_q;
    if (start) begin
      busy_d = 1'b1;
      cyc_d  = '0;
    end else if (kill) begin
      busy_d = 1'b0;
      cyc_d  = '0;
    end else if (busy_q && tick) begin
      if (cyc_q == LAST) begin
        busy_d = 1'b0;
        cyc_d  = '0;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cyc_q  <= cyc_d;
    end
  end

  assert_restart_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  assert_kill_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !busy_q);
endmodule

// File: rtl/adc_fe_regs.sv
module adc_fe_regs
  import adc_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              done,
  input  logic [DW-1:0]     sample_in,
  output logic              csr_wr,
  output logic [CHW-1:0]    chan,
  output logic              speed,
  output logic              slow,
  output logic              ampsel
);
  logic           flag_q, flag_d;
  logic           speed_q, speed_d;
  logic           en_q, en_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic           slow_q, slow_d;
  logic           amp_q, amp_d;
  logic [DW-1:0]  data_q, data_d;
  logic           amp_wr, data_rd;
  logic           unused_wbits;

  assign unused_wbits = ^{bus_wdata[7], bus_wdata[4:3], bus_wdata[1:0]};
  assign csr_wr  = bus_wr && (bus_addr == A_CSR);
  assign amp_wr  = bus_wr && (bus_addr == A_AMP);
  assign data_rd = bus_rd && (bus_addr == A_DATA);

  always_comb begin
    speed_d = speed_q;
    en_d    = en_q;
    ch_d    = ch_q;
    slow_d  = slow_q;
    amp_d   = amp_q;
    data_d  = data_q;
    flag_d  = flag_q;
    if (csr_wr) begin
      speed_d = bus_wdata[6];
      en_d    = bus_wdata[5];
      ch_d    = bus_wdata[2:0];
    end
    if (amp_wr) begin
      slow_d = bus_wdata[3];
      amp_d  = bus_wdata[2];
    end
    if (done) data_d = sample_in;
    if (csr_wr)       flag_d = 1'b0;
    else if (done)    flag_d = 1'b1;
    else if (data_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      speed_q <= 1'b0;
      en_q    <= 1'b0;
      ch_q    <= '0;
      slow_q  <= 1'b0;
      amp_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      flag_q  <= flag_d;
      speed_q <= speed_d;
      en_q    <= en_d;
      ch_q    <= ch_d;
      slow_q  <= slow_d;
      amp_q   <= amp_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CSR:   bus_rdata = {flag_q, speed_q, en_q, 2'b00, ch_q};
      A_DATA:  bus_rdata = data_q;
      A_AMP:   bus_rdata = {4'b0000, slow_q, amp_q, 2'b00};
      default: bus_rdata = '0;
    endcase
  end

  assign chan   = ch_q;
  assign speed  = speed_q;
  assign slow   = slow_q;
  assign ampsel = amp_q;

  assert_wr_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> !flag_q);
  assert_rd_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done && !csr_wr) |=> !flag_q);
  assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data_q));
endmodule

// File: rtl/adc_seq_frontend.sv
module adc_seq_frontend
  import adc_fe_pkg::*;
#(
  parameter int CONV_CYCLES = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     sample_in,
  output logic [CHW-1:0]    chan_sel,
  output logic              amp_sel,
  output logic              conv_busy,
  output logic              conv_tick
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       csr_wr, start, kill, done, busy, tick;
  logic       speed, slow;
  div_sel_e   div_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign start   = csr_wr && bus_wdata[5];
  assign kill    = csr_wr && !bus_wdata[5];
  assign div_sel = pick_div(slow, speed);

  adc_fe_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done      (done),
    .sample_in (sample_in),
    .csr_wr    (csr_wr),
    .chan      (chan_sel),
    .speed     (speed),
    .slow      (slow),
    .ampsel    (amp_sel)
  );

  adc_fe_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (busy),
    .restart (csr_wr),
    .div_sel (div_sel),
    .tick    (tick)
  );

  adc_fe_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .kill  (kill),
    .tick  (tick),
    .busy  (busy),
    .done  (done)
  );

  assign conv_busy = busy;
  assign conv_tick = tick;
endmodule

// File: tb/adc_seq_frontend_bench.sv
module adc_seq_frontend_bench;
  localparam int CONV = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, sample_in;
  logic [2:0] chan_sel;
  logic       amp_sel, conv_busy, conv_tick;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_seq_frontend #(.CONV_CYCLES(CONV)) u_adc_seq_frontend (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sample_in(sample_in), .chan_sel(chan_sel), .amp_sel(amp_sel),
    .conv_busy(conv_busy), .conv_tick(conv_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // combinational look at a register, no strobe, no side effect
  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // called right after wr(): check flag just before and just after the due edge
  task automatic expect_done(input string req, input int lat, input logic [7:0] smp);
    logic [7:0] v;
    int ticks = 0;
    for (int i = 0; i < lat - 1; i++) begin
      @(posedge clk); @(negedge clk);
    end
    peek(2'd0, v);
    check({req, " flag low before due edge"}, v[7], 0);
    check({req, " busy before due edge"}, conv_busy, 1);
    @(posedge clk); @(negedge clk);
    peek(2'd0, v);
    check({req, " flag set at due edge"}, v[7], 1);
    peek(2'd1, v);
    check({req, " result captured"}, v, smp);
    check({req, " busy clear after"}, conv_busy, 0);
    ticks = ticks;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(2'd0, v); check("R1 csr reset", v, 8'h00);
    peek(2'd1, v); check("R1 data reset", v, 8'h00);
    peek(2'd2, v); check("R1 amp reset", v, 8'h00);
    check("R1 busy reset", conv_busy, 0);
    check("R1 chan reset", chan_sel, 0);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    wr(2'd0, 8'hDF);            // flag/reserved bits set, enable=0
    peek(2'd0, v); check("R2 csr readback", v, 8'h47);
    check("R10 chan code 7", chan_sel, 7);
    wr(2'd0, 8'h05);
    check("R10 chan code 5", chan_sel, 5);
    wr(2'd2, 8'hFF);
    peek(2'd2, v); check("R3 amp readback", v, 8'h0C);
    check("R3 amp_sel high", amp_sel, 1);
    wr(2'd2, 8'hF3);
    peek(2'd2, v); check("R3 amp reserved zero", v, 8'h00);
    check("R3 amp_sel low", amp_sel, 0);
  endtask

  task automatic t_rates();
    wr(2'd2, 8'h00);
    sample_in = 8'hA5;
    wr(2'd0, 8'h21);           // speed0 -> /2
    expect_done("R4 div2", CONV*2, 8'hA5);
    sample_in = 8'h3C;
    wr(2'd0, 8'h62);           // speed1 -> /1
    expect_done("R4 div1", CONV, 8'h3C);
    wr(2'd2, 8'h08);           // slow
    sample_in = 8'hFF;
    wr(2'd0, 8'h23);
    expect_done("R5 slow speed0", CONV*4, 8'hFF);
    sample_in = 8'h00;
    wr(2'd0, 8'h64);
    expect_done("R5 slow speed1", CONV*4, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_clear_paths();
    logic [7:0] v;
    sample_in = 8'h5A;
    wr(2'd0, 8'h60);
    expect_done("R6 setup", CONV, 8'h5A);
    rd(2'd0, v); check("R6 csr read keeps flag", v[7], 1);
    rd(2'd2, v); peek(2'd0, v); check("R6 amp read keeps flag", v[7], 1);
    rd(2'd1, v); check("R6 read value", v, 8'h5A);
    peek(2'd0, v); check("R6 data read clears flag", v[7], 0);
    sample_in = 8'h77;
    wr(2'd0, 8'h60);
    expect_done("R7 setup", CONV, 8'h77);
    wr(2'd0, 8'h40);
    peek(2'd0, v); check("R7 disabled write clears flag", v[7], 0);
    check("R7 no restart", conv_busy, 0);
  endtask

  task automatic t_restart();
    sample_in = 8'h19;
    wr(2'd0, 8'h21);           // /2
    repeat (10) @(posedge clk);
    @(negedge clk);
    wr(2'd0, 8'h23);
    check("R8 new channel", chan_sel, 3);
    check("R8 busy after restart", conv_busy, 1);
    expect_done("R8 restart timing", CONV*2, 8'h19);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    sample_in = 8'hC3;
    wr(2'd0, 8'h60);
    repeat (5) @(posedge clk);
    @(negedge clk);
    wr(2'd0, 8'h40);
    check("R9 busy drops", conv_busy, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    peek(2'd0, v); check("R9 flag stays clear", v[7], 0);
    peek(2'd1, v); check("R9 data kept", v, 8'h19);
  endtask

  task automatic t_ticks();
    int cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (conv_tick) cnt++;
    end
    check("R11 no ticks idle", cnt, 0);
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h20);
    cnt = 0;
    for (int i = 0; i < CONV*4 + 10; i++) begin
      if (conv_tick) cnt++;
      @(negedge clk);
    end
    check("R11 ticks per conversion", cnt, CONV);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; sample_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_fields();
    t_rates();
    t_clear_paths();
    t_restart();
    t_disable();
    t_ticks();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule